// File: doc/BRIEF.md
# Operand Stack with Integrated ALU

This block is the data path of a zero-address machine. It holds a parameterised number of words in a last-in first-out arrangement and accepts one command per clock. The four commands are: push a word from the input bus, pop the top word onto the output bus, rewrite the top word through the ALU, or merge the two upper words through the ALU into a single result.

Every command is checked against the current occupancy before it takes effect. A command the stack cannot honour changes nothing and raises a one-cycle overflow or underflow pulse. Occupancy, full and empty are always visible. The top word is also shown on a dedicated output, so a controller can inspect it without popping it. All outputs come from registers.

Top module: `op_stack_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `depth`, sets `empty`, and clears `full`, `overflow`, `underflow`, `pop_valid` and `cmd_ready`.
- R2: A push (`cmd`=00) with `full` low increments `depth` by one and makes `top_data` equal to `push_data`. `full` rises when `depth` reaches DEPTH, which is when the last slot is occupied.
- R3: A push with `full` high leaves `depth` and all stored words unchanged. `overflow` is high for exactly the following cycle.
- R4: A pop (`cmd`=01) with `empty` low presents the previous top word on `pop_data` with `pop_valid` high for one cycle. It decrements `depth` and clears `full`, and the word below becomes `top_data`.
- R5: A pop with `empty` high changes nothing, keeps `pop_valid` low, and pulses `underflow` for one cycle.
- R6: A unary command (`cmd`=10) with at least one entry replaces the top word with f(top, top) and leaves `depth` unchanged. With no entries it changes nothing and pulses `underflow`.
- R7: A binary command (`cmd`=11) with at least two entries removes both upper words and pushes f(second, top), where the second word is operand a and the top word is operand b. `depth` drops by one. With fewer than two entries it changes nothing and pulses `underflow`.
- R8: `alu_op` selects f(a,b): 000 a+b, 001 a-b, 010 a AND b, 011 a OR b, 100 a XOR b, 101 a shifted left by one, 110 two's-complement negation of a, 111 bitwise inversion of a. All results wrap to WIDTH bits.
- R9: `empty` rises in the cycle after the last remaining entry is popped. `full` and `empty` are never high together.
- R10: A cycle with `cmd_valid` low changes no state and produces no pulse, whatever `cmd`, `alu_op` and `push_data` carry.
- R11: `cmd_ready` is high from the first clock edge after reset is released. Each accepted command completes in that single edge, with its results visible immediately after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_ready | output | 1 | Stack accepts a command this cycle |
| cmd | input | 2 | 00 push, 01 pop, 10 unary, 11 binary |
| alu_op | input | 3 | ALU function select (see R8) |
| push_data | input | WIDTH | Word to push |
| pop_data | output | WIDTH | Word removed by the last pop |
| pop_valid | output | 1 | One-cycle strobe for `pop_data` |
| top_data | output | WIDTH | Current top word (meaningful when not empty) |
| depth | output | $clog2(DEPTH+1) | Number of stored words |
| full | output | 1 | All DEPTH slots occupied |
| empty | output | 1 | No words stored |
| overflow | output | 1 | Pulse: last push was refused |
| underflow | output | 1 | Pulse: last pop, unary or binary was refused |

## Verification
The hardest state to reach from the ports is a refused push on a full stack, followed by proof that every buried word survived it. The stimulus fills the stack completely and pushes into it twice. It then drains the stack while comparing each popped word against the reference queue. A second delicate case is a binary command issued with exactly one entry, which must be refused even though the stack is not empty. A directed step creates this case, and the random phase revisits both edges often because its command mix favours pushes and binary merges.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    CMD_PUSH   = 2'd0,
    CMD_POP    = 2'd1,
    CMD_UNARY  = 2'd2,
    CMD_BINARY = 2'd3
  } stk_cmd_e;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_SHL = 3'd5,
    OP_NEG = 3'd6,
    OP_NOT = 3'd7
  } stk_op_e;
endpackage

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int WIDTH = 16
) (
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  import stk_pkg::*;

  always_comb begin
    unique case (stk_op_e'(op))
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SHL:  y = {a[WIDTH-2:0], 1'b0};
      OP_NEG:  y = ~a + 1'b1;
      default: y = ~a;
    endcase
  end
endmodule

// File: rtl/stk_store.sv
module stk_store #(
  parameter int WIDTH = 16,
  parameter int SLOTS = 7,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [SLOTS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  always_comb begin
    if (we) assert (int'(waddr) < SLOTS) else $error("p_store_bound_r2: write beyond body");
  end
endmodule

// File: rtl/stk_guard.sv
module stk_guard #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input  logic          go,
  input  logic [1:0]    cmd,
  input  logic [CW-1:0] cnt,
  output logic          accept,
  output logic          ovf,
  output logic          udf,
  output logic [CW-1:0] cnt_nxt
);
  import stk_pkg::*;

  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  always_comb begin
    accept  = 1'b0;
    ovf     = 1'b0;
    udf     = 1'b0;
    cnt_nxt = cnt;
    if (go) begin
      unique case (stk_cmd_e'(cmd))
        CMD_PUSH: begin
          if (cnt == CMAX) ovf = 1'b1;
          else begin
            accept  = 1'b1;
            cnt_nxt = cnt + 1'b1;
          end
        end
        CMD_POP: begin
          if (cnt == '0) udf = 1'b1;
          else begin
            accept  = 1'b1;
            cnt_nxt = cnt - 1'b1;
          end
        end
        CMD_UNARY: begin
          if (cnt == '0) udf = 1'b1;
          else accept = 1'b1;
        end
        default: begin
          if (cnt < CW'(2)) udf = 1'b1;
          else begin
            accept  = 1'b1;
            cnt_nxt = cnt - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/op_stack_unit.sv
module op_stack_unit #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd,
  input  logic [2:0]       alu_op,
  input  logic [WIDTH-1:0] push_data,
  output logic [WIDTH-1:0] pop_data,
  output logic             pop_valid,
  output logic [WIDTH-1:0] top_data,
  output logic [CW-1:0]    depth,
  output logic             full,
  output logic             empty,
  output logic             overflow,
  output logic             underflow
);
  import stk_pkg::*;

  localparam int SLOTS = DEPTH - 1;
  localparam int AW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [CW-1:0]    cnt_q, cnt_nxt;
  logic [WIDTH-1:0] tos_q, nos, alu_a, alu_y, dout_q;
  logic             rdy_q, full_q, empty_q, ovf_q, udf_q, dv_q;
  logic             go, accept, g_ovf, g_udf, body_we;
  logic [AW-1:0]    waddr, raddr;

  assign go = cmd_valid & rdy_q;

  stk_guard #(.DEPTH(DEPTH), .CW(CW)) u_guard (
    .go(go), .cmd(cmd), .cnt(cnt_q),
    .accept(accept), .ovf(g_ovf), .udf(g_udf), .cnt_nxt(cnt_nxt)
  );

  // Body holds every entry below the top; the top lives in tos_q.
  assign body_we = accept && (stk_cmd_e'(cmd) == CMD_PUSH) && (cnt_q != '0);
  assign waddr   = AW'(cnt_q - 1'b1);
  assign raddr   = (cnt_q >= CW'(2)) ? AW'(cnt_q - CW'(2)) : '0;

  stk_store #(.WIDTH(WIDTH), .SLOTS(SLOTS), .AW(AW)) u_body (
    .clk(clk), .we(body_we), .waddr(waddr), .wdata(tos_q),
    .raddr(raddr), .rdata(nos)
  );

  assign alu_a = (stk_cmd_e'(cmd) == CMD_BINARY) ? nos : tos_q;

  stk_alu #(.WIDTH(WIDTH)) u_alu (
    .op(alu_op), .a(alu_a), .b(tos_q), .y(alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      tos_q   <= '0;
      dout_q  <= '0;
      rdy_q   <= 1'b0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
      dv_q    <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      ovf_q <= g_ovf;
      udf_q <= g_udf;
      dv_q  <= accept && (stk_cmd_e'(cmd) == CMD_POP);
      if (accept) begin
        cnt_q   <= cnt_nxt;
        full_q  <= (cnt_nxt == CMAX);
        empty_q <= (cnt_nxt == '0);
        unique case (stk_cmd_e'(cmd))
          CMD_PUSH: tos_q <= push_data;
          CMD_POP: begin
            dout_q <= tos_q;
            tos_q  <= nos;
          end
          default: tos_q <= alu_y;
        endcase
      end
    end
  end

  assign cmd_ready = rdy_q;
  assign pop_data  = dout_q;
  assign pop_valid = dv_q;
  assign top_data  = tos_q;
  assign depth     = cnt_q;
  assign full      = full_q;
  assign empty     = empty_q;
  assign overflow  = ovf_q;
  assign underflow = udf_q;

  p_push_grow_r2: assert property (@(posedge clk) disable iff (rst)
    (go && cmd == 2'd0 && !full_q) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)) && (tos_q == $past(push_data)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (go && cmd == 2'd0 && full_q) |=> overflow && $stable(cnt_q) && $stable(tos_q));

  p_pop_out_r4: assert property (@(posedge clk) disable iff (rst)
    (go && cmd == 2'd1 && !empty_q) |=> pop_valid && (pop_data == $past(tos_q)) && !full);

  p_pop_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (go && cmd == 2'd1 && empty_q) |=> underflow && !pop_valid && $stable(cnt_q));

  p_unary_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (go && cmd == 2'd2) |=> $stable(cnt_q));

  p_binary_shrink_r7: assert property (@(posedge clk) disable iff (rst)
    (go && cmd == 2'd3 && cnt_q >= CW'(2)) |=> (cnt_q == CW'($past(cnt_q) - 1'b1)));

  p_flag_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !go |=> $stable(cnt_q) && $stable(tos_q) && !overflow && !underflow && !pop_valid);

  p_single_fault_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({overflow, underflow, pop_valid}));
endmodule

// File: tb/sim_op_stack_unit.sv
module sim_op_stack_unit;
  localparam int DEPTH = 8;
  localparam int WIDTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [1:0]       cmd = 2'd0;
  logic [2:0]       alu_op = 3'd0;
  logic [WIDTH-1:0] push_data = '0;
  logic [WIDTH-1:0] pop_data, top_data;
  logic             pop_valid, full, empty, overflow, underflow;
  logic [CW-1:0]    depth;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [WIDTH-1:0] q[$];
  bit               e_ov, e_uf, e_dv;
  logic [WIDTH-1:0] e_dout;

  always #2 clk = ~clk;

  op_stack_unit #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd(cmd), .alu_op(alu_op), .push_data(push_data), .pop_data(pop_data),
    .pop_valid(pop_valid), .top_data(top_data), .depth(depth), .full(full),
    .empty(empty), .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [WIDTH-1:0] fref(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                                            input logic [2:0] op);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return a << 1;
      3'd6: return 0 - a;
      default: return ~a;
    endcase
  endfunction

  // Compare every output with the reference queue (R2..R11 per cycle).
  task automatic compare();
    chk("R11", "cmd_ready", cmd_ready, 1);
    chk("R2", "depth", depth, q.size());
    chk("R2", "full", full, q.size() == DEPTH);
    chk("R9", "empty", empty, q.size() == 0);
    chk("R3", "overflow", overflow, e_ov);
    chk("R5", "underflow", underflow, e_uf);
    chk("R4", "pop_valid", pop_valid, e_dv);
    if (e_dv) chk("R4", "pop_data", pop_data, e_dout);
    if (q.size() > 0) chk("R7", "top_data", top_data, q[$]);
  endtask

  task automatic step(input bit v, input logic [1:0] c, input logic [2:0] op, input logic [WIDTH-1:0] d);
    logic [WIDTH-1:0] a, b;
    cmd_valid = v; cmd = c; alu_op = op; push_data = d;
    e_ov = 0; e_uf = 0; e_dv = 0;
    if (v) begin
      case (c)
        2'd0: if (q.size() == DEPTH) e_ov = 1; else q.push_back(d);
        2'd1: if (q.size() == 0) e_uf = 1; else begin e_dv = 1; e_dout = q.pop_back(); end
        2'd2: if (q.size() == 0) e_uf = 1; else begin a = q.pop_back(); q.push_back(fref(a, a, op)); end
        default: if (q.size() < 2) e_uf = 1;
                 else begin b = q.pop_back(); a = q.pop_back(); q.push_back(fref(a, b, op)); end
      endcase
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "depth", depth, 0);
    chk("R1", "empty", empty, 1);
    chk("R1", "full", full, 0);
    chk("R1", "overflow", overflow, 0);
    chk("R1", "underflow", underflow, 0);
    chk("R1", "pop_valid", pop_valid, 0);
    chk("R11", "ready in reset", cmd_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    e_ov = 0; e_uf = 0; e_dv = 0;
    compare();

    // R5 / R6 / R7: refusals on an empty stack
    step(1, 2'd1, 3'd0, 16'h0);
    step(1, 2'd2, 3'd5, 16'h0);
    step(1, 2'd3, 3'd0, 16'h0);
    // R7: binary with exactly one entry must be refused
    step(1, 2'd0, 3'd0, 16'h1234);
    step(1, 2'd3, 3'd0, 16'h0);
    chk("R7", "one-entry top kept", top_data, 16'h1234);
    step(1, 2'd1, 3'd0, 16'h0);
    chk("R9", "empty after last pop", empty, 1);

    // R2 / R3: fill, then push into a full stack twice
    for (int i = 0; i < DEPTH; i++) step(1, 2'd0, 3'd0, WIDTH'(16'hA000 + i * 16'h0111));
    chk("R2", "full after fill", full, 1);
    step(1, 2'd0, 3'd0, 16'hDEAD);
    step(1, 2'd0, 3'd0, 16'hBEEF);
    chk("R3", "top after refused push", top_data, 16'hA777);
    // R10: invalid cycles carrying garbage
    for (int i = 0; i < 4; i++) step(0, 2'(i), 3'(i), 16'hFFFF);
    // R4: drain and confirm buried contents
    for (int i = 0; i < DEPTH; i++) step(1, 2'd1, 3'd0, 16'h0);
    step(1, 2'd1, 3'd0, 16'h0);

    // R8: every function as binary and as unary
    for (int op = 0; op < 8; op++) begin
      step(1, 2'd0, 3'd0, 16'h8421);
      step(1, 2'd0, 3'd0, 16'h0F35);
      step(1, 2'd3, 3'(op), 16'h0);
      step(1, 2'd2, 3'(op), 16'h0);
      step(1, 2'd1, 3'd0, 16'h0);
    end

    // Random phase favouring pushes and binary merges
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [1:0] c;
      r = $urandom_range(0, 99);
      c = (r < 42) ? 2'd0 : (r < 64) ? 2'd1 : (r < 78) ? 2'd2 : 2'd3;
      step($urandom_range(0, 9) != 0, c, 3'($urandom_range(0, 7)), WIDTH'($urandom));
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule